// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides whether a single memory access may proceed, using a bank of protection entries. Each entry pairs an 8-bit configuration byte with an address register that holds a word address (the byte address shifted right by two). Three region shapes can be selected per entry: a range bounded by the previous entry's register ("top of range"), a single naturally aligned 4-byte word, and a naturally aligned power-of-two region whose size is encoded by trailing ones in the register. The lowest-numbered entry that matches decides the result.

Next to the matching rules, the checker applies the privilege policy. In the classic policy, machine mode is exempt from unlocked entries and bound by locked ones. A machine-mode-lockdown flag changes what each permission encoding means and adds shared regions for both privilege levels. A whitelist flag denies machine-mode accesses that hit no entry. The verdict, a hit flag, the index of the deciding entry and that entry's matching mode are registered, so they appear one clock after the inputs. The entry configuration is supplied as flat vectors by the surrounding register file.

Top module: `mpu_access_check`

## Requirements
- R1: Configuration byte layout: bit 7 lock, bits 4:3 mode (0 off, 1 top-of-range, 2 single word, 3 power-of-two), bit 2 X, bit 1 W, bit 0 R. An entry in mode 0 never matches.
- R2: Top-of-range entry i matches word address a = addr[XLEN+1:2] when prev <= a < reg_i, where prev is entry i-1's register, or zero for entry 0. When reg_i <= prev, the entry matches nothing.
- R3: A single-word entry matches only when a equals its register. When the GRAIN parameter is 1 or more, single-word entries never match.
- R4: A power-of-two entry whose register ends in k ones followed by a zero covers 2^(k+3) bytes and matches when a and the register agree in all bits above position k. An all-ones register matches every address.
- R5: When several entries match, the lowest index decides. hit_o is 1 and hit_idx_o / hit_mode_o give that entry's index and mode. With no match, all three read 0.
- R6: With lockdown clear, a machine-mode access that hits an unlocked entry is granted for read, write and execute.
- R7: With lockdown clear, a user-mode access, or a machine-mode access that hits a locked entry, is granted only when the entry's R, W or X bit for that access type is set. The encoding W=1 with R=0 grants nothing.
- R8: An access that hits no entry is denied in user mode and granted in machine mode while the whitelist flag is clear.
- R9: With the whitelist flag set, a machine-mode access that hits no entry is denied.
- R10: With lockdown set, outside the shared encodings, an unlocked entry gives its RWX bits to user mode only and a locked entry gives them to machine mode only.
- R11: With lockdown set, the shared encodings (L,R,W,X) grant as follows: 0010 gives machine RW and user R; 0011 gives RW to both; 1010 gives X to both; 1011 gives machine RX and user X; 1111 gives R to both.
- R12: Access type code 0 is read, 1 write, 2 execute. Code 3 is never granted.
- R13: Outputs are registered, so each result appears on the clock edge after its inputs. A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | NUM_ENTRIES*8 | Configuration bytes, entry i in bits [8i+7:8i] |
| addr_regs_i | input | NUM_ENTRIES*XLEN | Word-address registers, entry i in bits [XLEN*i+XLEN-1:XLEN*i] |
| acc_addr_i | input | XLEN+2 | Byte address of the access |
| acc_kind_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| priv_m_i | input | 1 | 1 = machine mode, 0 = user mode |
| mml_i | input | 1 | Machine-mode lockdown policy enable |
| mmwp_i | input | 1 | Machine-mode whitelist enable |
| grant_o | output | 1 | Access allowed |
| hit_o | output | 1 | Some entry matched |
| hit_idx_o | output | IDX_W | Index of the deciding entry |
| hit_mode_o | output | 2 | Matching mode of the deciding entry |

## Verification
On every cycle, the assertions check the rules that do not depend on region geometry: an idle hit report, a mode that is never 0 on a hit, denial of the reserved access type, the verdict on no-match accesses in both privileges and under the whitelist flag, and the machine-mode exemption for unlocked entries without lockdown. Whether the address arithmetic picks the right entry can only be shown by the bench's scenarios: top-of-range boundaries and illegal ranges, power-of-two sizes up to the all-ones register, priority among overlapping entries, and the full lockdown encoding table. The bench scores these against its own reference model.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  pad;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;
endpackage

// File: rtl/mpu_chk_entry.sv
module mpu_chk_entry
  import mpu_chk_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int GRAIN = 0
) (
  input  entry_cfg_t      cfg_i,
  input  logic [XLEN-1:0] reg_i,
  input  logic [XLEN-1:0] prev_i,
  input  logic [XLEN-1:0] word_i,
  output logic            hit_o
);
  logic [XLEN-1:0] size_mask;
  logic            tor_hit, na4_hit, napot_hit;

  // reg ^ (reg+1) sets the trailing ones and the first zero; all ones gives all ones
  assign size_mask = reg_i ^ (reg_i + 1'b1);
  assign tor_hit   = (prev_i <= word_i) && (word_i < reg_i);
  assign napot_hit = ((word_i ^ reg_i) & ~size_mask) == '0;

  generate
    if (GRAIN >= 1) begin : g_no_na4
      assign na4_hit = 1'b0;
    end else begin : g_na4
      assign na4_hit = (word_i == reg_i);
    end
  endgenerate

  always_comb begin
    unique case (cfg_i.mode)
      MODE_TOR:   hit_o = tor_hit;
      MODE_NA4:   hit_o = na4_hit;
      MODE_NAPOT: hit_o = napot_hit;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mpu_chk_prio.sv
module mpu_chk_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |hits_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mpu_chk_perm.sv
module mpu_chk_perm
  import mpu_chk_pkg::*;
(
  input  entry_cfg_t cfg_i,
  input  logic       hit_i,
  input  logic       priv_m_i,
  input  logic       mml_i,
  input  logic       mmwp_i,
  input  acc_kind_e  kind_i,
  output logic       grant_o
);
  logic [2:0] rwx;      // {x,w,r}
  logic [2:0] m_perm, u_perm, perm;
  logic       allowed;

  assign rwx = {cfg_i.x, cfg_i.w, cfg_i.r};

  always_comb begin
    m_perm = 3'b000;
    u_perm = 3'b000;
    if (!mml_i) begin
      u_perm = (cfg_i.w && !cfg_i.r) ? 3'b000 : rwx;
      m_perm = cfg_i.lock ? u_perm : 3'b111;
    end else begin
      unique case ({cfg_i.lock, cfg_i.r, cfg_i.w, cfg_i.x})
        4'b0010: begin m_perm = 3'b011; u_perm = 3'b001; end
        4'b0011: begin m_perm = 3'b011; u_perm = 3'b011; end
        4'b1010: begin m_perm = 3'b100; u_perm = 3'b100; end
        4'b1011: begin m_perm = 3'b101; u_perm = 3'b100; end
        4'b1111: begin m_perm = 3'b001; u_perm = 3'b001; end
        default: begin
          if (cfg_i.lock) m_perm = rwx;
          else            u_perm = rwx;
        end
      endcase
    end
  end

  assign perm = priv_m_i ? m_perm : u_perm;

  always_comb begin
    if (!hit_i) allowed = priv_m_i && !mmwp_i;
    else begin
      unique case (kind_i)
        ACC_READ:  allowed = perm[0];
        ACC_WRITE: allowed = perm[1];
        ACC_EXEC:  allowed = perm[2];
        default:   allowed = 1'b0;
      endcase
    end
    grant_o = allowed && (kind_i != ACC_RSVD);
  end
endmodule

// File: rtl/mpu_access_check.sv
module mpu_access_check
  import mpu_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int GRAIN       = 0,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NUM_ENTRIES*8-1:0]    cfg_i,
  input  logic [NUM_ENTRIES*XLEN-1:0] addr_regs_i,
  input  logic [XLEN+1:0]             acc_addr_i,
  input  logic [1:0]                  acc_kind_i,
  input  logic                        priv_m_i,
  input  logic                        mml_i,
  input  logic                        mmwp_i,
  output logic                        grant_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o,
  output logic [1:0]                  hit_mode_o
);
  logic [XLEN-1:0]        word;
  logic [NUM_ENTRIES-1:0] hits;
  logic                   any_hit;
  logic [IDX_W-1:0]       sel_idx;
  entry_cfg_t             sel_cfg;
  logic                   grant_d;

  assign word = acc_addr_i[XLEN+1:2];

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      logic [XLEN-1:0] prev;
      if (i == 0) begin : g_first
        assign prev = '0;
      end else begin : g_rest
        assign prev = addr_regs_i[(i-1)*XLEN +: XLEN];
      end
      mpu_chk_entry #(.XLEN(XLEN), .GRAIN(GRAIN)) u_entry (
        .cfg_i  (entry_cfg_t'(cfg_i[i*8 +: 8])),
        .reg_i  (addr_regs_i[i*XLEN +: XLEN]),
        .prev_i (prev),
        .word_i (word),
        .hit_o  (hits[i])
      );
    end
  endgenerate

  mpu_chk_prio #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .hits_i (hits),
    .any_o  (any_hit),
    .idx_o  (sel_idx)
  );

  assign sel_cfg = entry_cfg_t'(cfg_i[sel_idx*8 +: 8]);

  mpu_chk_perm u_perm (
    .cfg_i    (sel_cfg),
    .hit_i    (any_hit),
    .priv_m_i (priv_m_i),
    .mml_i    (mml_i),
    .mmwp_i   (mmwp_i),
    .kind_i   (acc_kind_e'(acc_kind_i)),
    .grant_o  (grant_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      grant_o    <= 1'b0;
      hit_o      <= 1'b0;
      hit_idx_o  <= '0;
      hit_mode_o <= 2'b00;
    end else begin
      grant_o    <= grant_d;
      hit_o      <= any_hit;
      hit_idx_o  <= any_hit ? sel_idx : '0;
      hit_mode_o <= any_hit ? sel_cfg.mode : 2'b00;
    end
  end
endmodule

// File: rtl/mpu_access_check_sva.sv
module mpu_access_check_sva #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 3
) (
  input logic                     clk_i,
  input logic                     rst_i,
  input logic [NUM_ENTRIES*8-1:0] cfg_i,
  input logic [1:0]               acc_kind_i,
  input logic                     priv_m_i,
  input logic                     mml_i,
  input logic                     mmwp_i,
  input logic                     grant_o,
  input logic                     hit_o,
  input logic [IDX_W-1:0]         hit_idx_o,
  input logic [1:0]               hit_mode_o
);
  logic [NUM_ENTRIES*8-1:0] cfg_q;
  logic                     lock_q;

  always_ff @(posedge clk_i) cfg_q <= cfg_i;
  assign lock_q = cfg_q[int'(hit_idx_o)*8 + 7];

  a_r5_idle_report: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit_o |-> (hit_idx_o == '0 && hit_mode_o == 2'b00));

  a_r1_off_never_hits: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> hit_mode_o != 2'b00);

  a_r12_rsvd_kind_denied: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i && acc_kind_i == 2'd3) |-> !grant_o);

  a_r8_user_nomatch_deny: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i && !priv_m_i) && !hit_o) |-> !grant_o);

  a_r8_machine_nomatch_allow: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i && priv_m_i && !mmwp_i && acc_kind_i != 2'd3) && !hit_o) |-> grant_o);

  a_r9_whitelist_deny: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i && priv_m_i && mmwp_i) && !hit_o) |-> !grant_o);

  a_r6_unlocked_machine: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i && priv_m_i && !mml_i && acc_kind_i != 2'd3) && hit_o && !lock_q)
      |-> grant_o);
endmodule

bind mpu_access_check mpu_access_check_sva #(
  .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
) u_sva (
  .clk_i(clk_i), .rst_i(rst_i), .cfg_i(cfg_i), .acc_kind_i(acc_kind_i),
  .priv_m_i(priv_m_i), .mml_i(mml_i), .mmwp_i(mmwp_i), .grant_o(grant_o),
  .hit_o(hit_o), .hit_idx_o(hit_idx_o), .hit_mode_o(hit_mode_o)
);

// File: tb/mpu_access_check_tb.sv
module mpu_access_check_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE   = 8;
  localparam int XL   = 32;
  localparam int IW   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NE*8-1:0]   cfg_v = '0;
  logic [NE*XL-1:0]  regs_v = '0;
  logic [XL+1:0]     addr = '0;
  logic [1:0]        kind = '0;
  logic              pm = 1'b0, mml = 1'b0, mmwp = 1'b0;
  logic              grant, hit, g1_grant, g1_hit;
  logic [IW-1:0]     idx, g1_idx;
  logic [1:0]        mode, g1_mode;

  logic [7:0]        cfg_a [NE];
  logic [XL-1:0]     reg_a [NE];
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_access_check #(.NUM_ENTRIES(NE), .XLEN(XL), .GRAIN(0)) u_dut (
    .clk_i(clk), .rst_i(rst), .cfg_i(cfg_v), .addr_regs_i(regs_v), .acc_addr_i(addr),
    .acc_kind_i(kind), .priv_m_i(pm), .mml_i(mml), .mmwp_i(mmwp),
    .grant_o(grant), .hit_o(hit), .hit_idx_o(idx), .hit_mode_o(mode));

  mpu_access_check #(.NUM_ENTRIES(NE), .XLEN(XL), .GRAIN(1)) u_dut_g1 (
    .clk_i(clk), .rst_i(rst), .cfg_i(cfg_v), .addr_regs_i(regs_v), .acc_addr_i(addr),
    .acc_kind_i(kind), .priv_m_i(pm), .mml_i(mml), .mmwp_i(mmwp),
    .grant_o(g1_grant), .hit_o(g1_hit), .hit_idx_o(g1_idx), .hit_mode_o(g1_mode));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_idx(logic [XL-1:0] a, int grain);
    for (int i = 0; i < NE; i++) begin
      logic [XL-1:0] lo = (i == 0) ? '0 : reg_a[i-1];
      logic [XL-1:0] r  = reg_a[i];
      bit m = 0;
      case (cfg_a[i][4:3])
        2'd1: m = (lo <= a) && (a < r);
        2'd2: m = (grain == 0) && (a == r);
        2'd3: begin
          int k = 0;
          while (k < XL && r[k]) k++;
          if (k >= XL - 1) m = (k == XL) ? 1'b1 : (a[XL-1] == r[XL-1]);
          else m = ((a >> (k + 1)) == (r >> (k + 1)));
        end
        default: m = 0;
      endcase
      if (m) return i;
    end
    return -1;
  endfunction

  function automatic bit ref_grant(int id, int k, bit m, bit lk, bit wp);
    logic [7:0] c;
    bit l, r, w, x;
    logic [2:0] p;
    if (k == 3) return 0;
    if (id < 0) return m && !wp;
    c = cfg_a[id]; l = c[7]; x = c[2]; w = c[1]; r = c[0];
    if (!lk) begin
      if (m && !l) p = 3'b111;
      else if (w && !r) p = 3'b000;
      else p = c[2:0];
    end else if (!r && w) begin
      if (!l) p = m ? 3'b011 : (x ? 3'b011 : 3'b001);
      else    p = m ? (x ? 3'b101 : 3'b100) : 3'b100;
    end else if (l && r && w && x) p = 3'b001;
    else if (l) p = m ? c[2:0] : 3'b000;
    else        p = m ? 3'b000 : c[2:0];
    return p[k];
  endfunction

  task automatic run(string req, logic [XL+1:0] a, int k, bit m, bit lk, bit wp);
    int ei, gi;
    @(negedge clk);
    for (int i = 0; i < NE; i++) begin
      cfg_v[i*8 +: 8]   = cfg_a[i];
      regs_v[i*XL +: XL] = reg_a[i];
    end
    addr = a; kind = 2'(k); pm = m; mml = lk; mmwp = wp;
    ei = ref_idx(a[XL+1:2], 0);
    gi = ref_idx(a[XL+1:2], 1);
    @(negedge clk);
    check(req, 32'(grant), 32'(ref_grant(ei, k, m, lk, wp)));
    check(req, 32'(hit), 32'(ei >= 0));
    check(req, 32'(idx), (ei >= 0) ? 32'(ei) : 32'd0);
    check(req, 32'(mode), (ei >= 0) ? 32'(cfg_a[ei][4:3]) : 32'd0);
    check(req, 32'(g1_hit), 32'(gi >= 0));
    check(req, 32'(g1_grant), 32'(ref_grant(gi, k, m, lk, wp)));
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NE; i++) begin cfg_a[i] = 8'h00; reg_a[i] = '0; end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_cfg();
    cfg_a[0] = 8'h0F; reg_a[0] = 32'hFFFF_FFFF;
    for (int i = 0; i < NE; i++) begin
      cfg_v[i*8 +: 8] = cfg_a[i]; regs_v[i*XL +: XL] = reg_a[i];
    end
    pm = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 reset", {29'd0, grant, hit, |idx}, 32'd0);
    check("R13 reset", 32'(mode), 32'd0);
    rst = 1'b0;

    // R13: first result after reset
    run("R13", 34'h40, 0, 1, 0, 0);

    // R2: top-of-range, entry 0 lower bound is zero, upper bound exclusive
    clear_cfg();
    cfg_a[0] = 8'h08 | 8'h01; reg_a[0] = 32'h10;
    run("R2", 34'h0, 0, 0, 0, 0);
    check("R2 low edge hit", 32'(hit), 32'd1);
    run("R2", 34'h3C, 0, 0, 0, 0);
    check("R2 below top", 32'(hit), 32'd1);
    run("R2", 34'h40, 0, 0, 0, 0);
    check("R2 top excluded", 32'(hit), 32'd0);
    // R2: illegal range (top below previous) matches nothing
    cfg_a[0] = 8'h00; reg_a[0] = 32'h20;
    cfg_a[1] = 8'h0F; reg_a[1] = 32'h10;
    run("R2", 34'h60, 0, 0, 0, 0);
    check("R2 illegal range", 32'(hit), 32'd0);

    // R3: single word exact match, disabled with GRAIN=1
    clear_cfg();
    cfg_a[0] = 8'h17; reg_a[0] = 32'h25;
    run("R3", 34'h94, 1, 0, 0, 0);
    check("R3 na4 hit", 32'(hit), 32'd1);
    check("R3 grain disables", 32'(g1_hit), 32'd0);
    run("R3", 34'h98, 1, 0, 0, 0);

    // R4: power-of-two, 32 bytes at 0x80 (reg = 0x20 | 0b11)
    clear_cfg();
    cfg_a[0] = 8'h1F; reg_a[0] = 32'h23;
    run("R4", 34'h9C, 0, 0, 0, 0);
    check("R4 inside", 32'(hit), 32'd1);
    run("R4", 34'hA0, 0, 0, 0, 0);
    check("R4 outside", 32'(hit), 32'd0);
    reg_a[0] = 32'hFFFF_FFFF;
    run("R4", 34'h3_FFFF_FFFC, 2, 0, 0, 0);
    check("R4 all ones", 32'(hit), 32'd1);

    // R5: priority among overlapping entries
    clear_cfg();
    cfg_a[2] = 8'h19; reg_a[2] = 32'h0F;
    cfg_a[5] = 8'h1F; reg_a[5] = 32'h0F;
    run("R5", 34'h04, 1, 0, 0, 0);
    check("R5 lowest wins", 32'(idx), 32'd2);
    check("R1 off entries skipped", 32'(mode), 32'd3);

    // R6/R7: machine exemption, lock, reserved W-only
    clear_cfg();
    cfg_a[0] = 8'h1A; reg_a[0] = 32'h0F;
    run("R6", 34'h08, 0, 1, 0, 0);
    run("R7", 34'h08, 1, 0, 0, 0);
    check("R7 reserved W only", 32'(grant), 32'd0);
    cfg_a[0] = 8'h99;
    run("R7", 34'h08, 1, 1, 0, 0);
    check("R7 locked denies write", 32'(grant), 32'd0);

    // R8/R9: no match
    clear_cfg();
    run("R8", 34'h100, 0, 0, 0, 0);
    run("R8", 34'h100, 2, 1, 0, 0);
    run("R9", 34'h100, 0, 1, 0, 1);
    check("R9 whitelist", 32'(grant), 32'd0);

    // R10/R11: lockdown table, every encoding, both privileges, all kinds
    for (int e = 0; e < 16; e++) begin
      clear_cfg();
      cfg_a[0] = {e[3], 2'b00, 2'b11, e[0], e[1], e[2]};
      reg_a[0] = 32'hFFFF_FFFF;
      for (int k = 0; k < 4; k++) begin
        run(((e & 7) == 2 || (e & 7) == 3 || e == 15) ? "R11" : "R10", 34'h10, k, 1, 1, 0);
        run(((e & 7) == 2 || (e & 7) == 3 || e == 15) ? "R11" : "R10", 34'h10, k, 0, 1, 0);
      end
    end

    // R12: reserved access kind
    clear_cfg();
    run("R12", 34'h10, 3, 1, 0, 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [XL+1:0] a;
      for (int i = 0; i < NE; i++) begin
        int kk = $urandom_range(0, 4);
        logic [XL-1:0] base = XL'($urandom_range(0, 63));
        cfg_a[i] = 8'($urandom) & 8'h9F;
        if (cfg_a[i][4:3] == 2'd3)
          reg_a[i] = ($urandom_range(0, 49) == 0) ? '1 :
                     ((base & ~((XL'(1) << (kk + 1)) - 1)) | ((XL'(1) << kk) - 1));
        else reg_a[i] = base;
      end
      a = {XL'($urandom_range(0, 70)), 2'($urandom)};
      if ($urandom_range(0, 19) == 0) a[XL+1:XL-4] = 6'($urandom);
      run("R5 random", a, $urandom_range(0, 3), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule